// File: doc/BRIEF.md
# In-Order Retirement Buffer with Speculative Register Recovery

This block keeps a circular window of in-flight instructions in program order while their results arrive in any order. Each instruction is given a slot when it is allocated and names the register it will write. When the execution side reports a result for a slot, the result goes straight into a speculative frontend register file. The slot then waits until it is the oldest. Only then is it retired and its value written into a separate architectural register file. As a result, the architectural copy only ever changes in program order.

A result can carry an exception flag. When the oldest slot holds a finished result with that flag set, the block does not retire it. It signals the exception for one cycle. In the same cycle it discards every slot in the window and copies the whole architectural file over the frontend file, so the frontend view falls back to the last precise state. Both files can be read combinationally through their own read ports. Fetch, scheduling and execution lie outside the block.

Top module: `rob_precise`

## Requirements
- R1: After reset the window is empty. `alloc_ok` is 1, `alloc_idx` is 0, `retire_valid` and `exc_taken` are 0, and every register of both files reads 0.
- R2: Each accepted allocation returns the current tail slot on `alloc_idx`. Slot numbers rise by one per allocation and wrap from 15 to 0.
- R3: With 16 slots occupied, `alloc_ok` is 0 and a request has no effect. Once the head retires, the next allocation gets the slot that follows the last accepted one.
- R4: A completion for an occupied slot writes its value into the frontend register named at allocation. The value is readable on `fe_rd_data` in the cycle after the completion. This also applies when the completion carries the exception flag.
- R5: A completion that names an unoccupied slot changes no register of the frontend file.
- R6: Slots retire strictly in allocation order, at most one per cycle. A finished younger slot waits behind an unfinished older one. While the head is finished and clean, `retire_valid` is 1 and `retire_idx`, `retire_dst` and `retire_data` show that head.
- R7: The architectural file changes only at the clock edge that ends a cycle with `retire_valid` at 1, and it takes the retiring value into the retiring register.
- R8: While the head slot is finished with its exception flag set, `exc_taken` is 1 for exactly one cycle. `retire_valid` is 0 during that cycle and the architectural file is not written.
- R9: After the exception cycle the window is empty, the next allocation gets slot 0, and every frontend register equals the architectural register of the same number.
- R10: During the exception cycle `alloc_ok` is 0, and a completion presented in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request a new slot |
| alloc_dst | input | 3 | Register the new instruction will write |
| alloc_ok | output | 1 | A request in this cycle is accepted |
| alloc_idx | output | 4 | Slot given to an accepted request |
| cmp_valid | input | 1 | A completion is presented |
| cmp_idx | input | 4 | Slot that completed |
| cmp_data | input | 16 | Result value |
| cmp_exc | input | 1 | The result raised an exception |
| retire_valid | output | 1 | Head slot retires this cycle |
| retire_idx | output | 4 | Slot being retired |
| retire_dst | output | 3 | Register being written architecturally |
| retire_data | output | 16 | Value being written architecturally |
| exc_taken | output | 1 | Head exception recovery this cycle |
| fe_rd_addr | input | 3 | Frontend file read address |
| fe_rd_data | output | 16 | Frontend file read value |
| arch_rd_addr | input | 3 | Architectural file read address |
| arch_rd_data | output | 16 | Architectural file read value |

## Verification
The bench completes slots out of order. A design that retired a finished younger slot ahead of an unfinished older one would show up as a scoreboard mismatch on `retire_idx`. It fills the window past the wrap of the slot number and then requests one more. A design without the wrap bit would read full as empty and overwrite the head, and one that advanced the tail on a refused request would hand out the wrong slot after the next retire. It completes the oldest slot with the exception flag while another completion and an allocation are presented in the same cycle. A design that wrote the architectural file, accepted the late inputs or skipped the copy would leave the frontend register holding the speculative value. Completions aimed at free slots catch a design that writes the frontend file from stale slot contents.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    HEAD_IDLE    = 2'd0,
    HEAD_RETIRE  = 2'd1,
    HEAD_RECOVER = 2'd2
  } head_action_e;

  // Decide what the oldest slot does this cycle.
  function automatic head_action_e head_decide(input logic vld, input logic fin, input logic exc);
    if (vld && fin) return exc ? HEAD_RECOVER : HEAD_RETIRE;
    return HEAD_IDLE;
  endfunction

  // Pointers carry one wrap bit above iw index bits.
  function automatic logic ptrs_full(input logic [31:0] h, input logic [31:0] t, input int unsigned iw);
    logic [31:0] lo_mask;
    lo_mask = (32'd1 << iw) - 32'd1;
    return (((h ^ t) & lo_mask) == 32'd0) && (h[iw] != t[iw]);
  endfunction

  function automatic logic [31:0] ptrs_count(input logic [31:0] h, input logic [31:0] t, input int unsigned iw);
    return (t - h) & ((32'd1 << (iw + 1)) - 32'd1);
  endfunction

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);
  import rob_pkg::*;

  logic [IDX_W:0] head_q, tail_q;
  logic [31:0]    occupancy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire)  tail_q <= tail_q + 1'b1;
      if (retire_fire) head_q <= head_q + 1'b1;
    end
  end

  assign head_idx  = head_q[IDX_W-1:0];
  assign tail_idx  = tail_q[IDX_W-1:0];
  assign full      = ptrs_full(32'(head_q), 32'(tail_q), IDX_W);
  assign empty     = (head_q == tail_q);
  assign occupancy = ptrs_count(32'(head_q), 32'(tail_q), IDX_W);

  a_r3_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= 32'(DEPTH));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  a_r6_retire_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |-> !empty);

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH  = 16,
  parameter int RA_W   = 3,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_fire,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [RA_W-1:0]   alloc_dst,
  input  logic              cmp_fire,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  input  logic              retire_fire,
  input  logic [IDX_W-1:0]  head_idx,
  output logic              cmp_hit,
  output logic [RA_W-1:0]   cmp_dst,
  output logic              head_valid,
  output logic              head_done,
  output logic              head_exc,
  output logic [RA_W-1:0]   head_dst,
  output logic [DATA_W-1:0] head_data
);

  logic [DEPTH-1:0]  valid_q, done_q, exc_q;
  logic [RA_W-1:0]   dst_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        dst_q[e]  <= '0;
        data_q[e] <= '0;
      end
    end else if (flush) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_fire && alloc_idx == IDX_W'(e)) begin
          valid_q[e] <= 1'b1;
          done_q[e]  <= 1'b0;
          exc_q[e]   <= 1'b0;
          dst_q[e]   <= alloc_dst;
        end else if (cmp_fire && cmp_idx == IDX_W'(e)) begin
          done_q[e]  <= 1'b1;
          exc_q[e]   <= cmp_exc;
          data_q[e]  <= cmp_data;
        end
        if (retire_fire && head_idx == IDX_W'(e)) begin
          valid_q[e] <= 1'b0;
          done_q[e]  <= 1'b0;
        end
      end
    end
  end

  assign cmp_hit    = valid_q[cmp_idx];
  assign cmp_dst    = dst_q[cmp_idx];
  assign head_valid = valid_q[head_idx];
  assign head_done  = done_q[head_idx];
  assign head_exc   = exc_q[head_idx];
  assign head_dst   = dst_q[head_idx];
  assign head_data  = data_q[head_idx];

  a_r2_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !valid_q[alloc_idx]);

  a_r6_retired_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> !valid_q[$past(head_idx)]);

  a_r5_only_live_completes: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |-> valid_q[cmp_idx]);

endmodule

// File: rtl/rob_regfile.sv
module rob_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [RA_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   restore,
  input  logic [NREG*DATA_W-1:0] restore_img,
  input  logic [RA_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] img
);

  logic [DATA_W-1:0] regs_q [NREG];

  // Restore has priority over a same-cycle write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else if (restore) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= restore_img[r*DATA_W +: DATA_W];
    end else if (wr_en) begin
      regs_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_img
    assign img[g*DATA_W +: DATA_W] = regs_q[g];
  end

endmodule

// File: rtl/rob_precise.sv
module rob_precise #(
  parameter int DEPTH  = 16,
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [RA_W-1:0]   alloc_dst,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  output logic              retire_valid,
  output logic [IDX_W-1:0]  retire_idx,
  output logic [RA_W-1:0]   retire_dst,
  output logic [DATA_W-1:0] retire_data,
  output logic              exc_taken,
  input  logic [RA_W-1:0]   fe_rd_addr,
  output logic [DATA_W-1:0] fe_rd_data,
  input  logic [RA_W-1:0]   arch_rd_addr,
  output logic [DATA_W-1:0] arch_rd_data
);
  import rob_pkg::*;

  // Named internal events
  logic              alloc_fire, cmp_fire, retire_fire, flush;
  logic              full, empty, cmp_hit;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [RA_W-1:0]   cmp_dst, head_dst;
  logic              head_valid, head_done, head_exc;
  logic [DATA_W-1:0] head_data;
  logic [NREG*DATA_W-1:0] fe_img, arch_img;
  head_action_e      head_act;

  assign head_act    = head_decide(head_valid, head_done, head_exc);
  assign retire_fire = (head_act == HEAD_RETIRE);
  assign flush       = (head_act == HEAD_RECOVER);
  assign alloc_ok    = !full && !flush;
  assign alloc_fire  = alloc_req && alloc_ok;
  assign cmp_fire    = cmp_valid && cmp_hit && !flush;

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire), .flush(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  rob_entry_array #(.DEPTH(DEPTH), .RA_W(RA_W), .DATA_W(DATA_W)) u_ent (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_fire(alloc_fire), .alloc_idx(tail_idx), .alloc_dst(alloc_dst),
    .cmp_fire(cmp_fire), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .retire_fire(retire_fire), .head_idx(head_idx),
    .cmp_hit(cmp_hit), .cmp_dst(cmp_dst),
    .head_valid(head_valid), .head_done(head_done), .head_exc(head_exc),
    .head_dst(head_dst), .head_data(head_data)
  );

  rob_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_fe_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmp_fire), .wr_addr(cmp_dst), .wr_data(cmp_data),
    .restore(flush), .restore_img(arch_img),
    .rd_addr(fe_rd_addr), .rd_data(fe_rd_data), .img(fe_img)
  );

  rob_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_arch_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(retire_fire), .wr_addr(head_dst), .wr_data(head_data),
    .restore(1'b0), .restore_img(fe_img),
    .rd_addr(arch_rd_addr), .rd_data(arch_rd_data), .img(arch_img)
  );

  assign alloc_idx    = tail_idx;
  assign retire_valid = retire_fire;
  assign retire_idx   = head_idx;
  assign retire_dst   = head_dst;
  assign retire_data  = head_data;
  assign exc_taken    = flush;

  a_r7_arch_only_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_fire |=> $stable(arch_img));

  a_r9_frontend_restored: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fe_img == $past(arch_img)));

  a_r8_exc_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> !exc_taken);

  a_r9_empty_after_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> (empty && alloc_idx == '0));

endmodule

// File: tb/rob_precise_tb.sv
module rob_precise_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic [2:0]  alloc_dst = '0;
  logic        alloc_ok;
  logic [3:0]  alloc_idx;
  logic        cmp_valid = 1'b0;
  logic [3:0]  cmp_idx = '0;
  logic [15:0] cmp_data = '0;
  logic        cmp_exc = 1'b0;
  logic        retire_valid;
  logic [3:0]  retire_idx;
  logic [2:0]  retire_dst;
  logic [15:0] retire_data;
  logic        exc_taken;
  logic [2:0]  fe_rd_addr = '0;
  logic [15:0] fe_rd_data;
  logic [2:0]  arch_rd_addr = '0;
  logic [15:0] arch_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int n_ret = 0;
  int q_idx[$];
  int q_dst[$];
  logic [15:0] mdl_data [16];

  always #4 clk = ~clk;

  rob_precise u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_dst(alloc_dst), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .retire_valid(retire_valid), .retire_idx(retire_idx), .retire_dst(retire_dst),
    .retire_data(retire_data), .exc_taken(exc_taken),
    .fe_rd_addr(fe_rd_addr), .fe_rd_data(fe_rd_data),
    .arch_rd_addr(arch_rd_addr), .arch_rd_data(arch_rd_data)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic fe_is(input int a, input logic [15:0] exp, input string req);
    fe_rd_addr = 3'(a);
    #1;
    check(req, $sformatf("frontend r%0d", a), 32'(fe_rd_data), 32'(exp));
  endtask

  task automatic arch_is(input int a, input logic [15:0] exp, input string req);
    arch_rd_addr = 3'(a);
    #1;
    check(req, $sformatf("arch r%0d", a), 32'(arch_rd_data), 32'(exp));
  endtask

  // Driver: one allocation cycle, pushes expected retirement
  task automatic alloc(input int dst, input int exp_idx, input string req);
    alloc_req = 1'b1;
    alloc_dst = 3'(dst);
    #1;
    check(req, "alloc_ok", 32'(alloc_ok), 32'd1);
    check(req, "alloc_idx", 32'(alloc_idx), 32'(exp_idx));
    q_idx.push_back(exp_idx);
    q_dst.push_back(dst);
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic complete(input int idx, input logic [15:0] d, input logic ex);
    cmp_valid = 1'b1;
    cmp_idx   = 4'(idx);
    cmp_data  = d;
    cmp_exc   = ex;
    mdl_data[idx] = d;
    @(negedge clk);
    cmp_valid = 1'b0;
    cmp_exc   = 1'b0;
  endtask

  // Monitor: scoreboard of in-order retirements (R6)
  always @(negedge clk) begin
    #2;
    if (rst_n && retire_valid) begin
      n_ret++;
      if (q_idx.size() == 0) begin
        check("R6", "unexpected retire_valid", 32'd1, 32'd0);
      end else begin
        int ei, ed;
        ei = q_idx.pop_front();
        ed = q_dst.pop_front();
        check("R6", "retire_idx", 32'(retire_idx), 32'(ei));
        check("R6", "retire_dst", 32'(retire_dst), 32'(ed));
        check("R6", "retire_data", 32'(retire_data), 32'(mdl_data[ei]));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    check("WDOG", "watchdog expired", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1;
    check("R1", "alloc_ok", 32'(alloc_ok), 32'd1);
    check("R1", "alloc_idx", 32'(alloc_idx), 32'd0);
    check("R1", "retire_valid", 32'(retire_valid), 32'd0);
    check("R1", "exc_taken", 32'(exc_taken), 32'd0);
    for (int r = 0; r < 8; r++) begin
      fe_is(r, 16'h0, "R1");
      arch_is(r, 16'h0, "R1");
    end

    // R2 in-order indices; R4/R6 out-of-order completion
    alloc(1, 0, "R2");
    alloc(2, 1, "R2");
    alloc(3, 2, "R2");
    complete(2, 16'h3333, 1'b0);
    fe_is(3, 16'h3333, "R4");
    arch_is(3, 16'h0, "R7");
    check("R6", "younger done waits", 32'(retire_valid), 32'd0);
    complete(0, 16'h1111, 1'b0);
    check("R6", "head retires", 32'(retire_valid), 32'd1);
    complete(1, 16'h2222, 1'b0);
    repeat (3) @(negedge clk);
    arch_is(1, 16'h1111, "R7");
    arch_is(2, 16'h2222, "R7");
    arch_is(3, 16'h3333, "R7");
    check("R6", "retire count", 32'(n_ret), 32'd3);

    // R5 completions to free slots
    complete(9, 16'hFFFF, 1'b0);
    complete(0, 16'hDEAD, 1'b0);
    fe_is(0, 16'h0, "R5");
    fe_is(1, 16'h1111, "R5");

    // R3 full window with wrap
    for (int k = 0; k < 16; k++) alloc(4, (3 + k) % 16, "R3");
    #1;
    check("R3", "alloc_ok when full", 32'(alloc_ok), 32'd0);
    alloc_req = 1'b1;
    alloc_dst = 3'd7;
    @(negedge clk);
    alloc_req = 1'b0;
    complete(3, 16'h4444, 1'b0);
    @(negedge clk);
    #1;
    check("R3", "alloc_ok after retire", 32'(alloc_ok), 32'd1);
    check("R3", "next slot", 32'(alloc_idx), 32'd3);
    arch_is(4, 16'h4444, "R7");

    // R8 head exception; R10 inputs during recovery
    complete(4, 16'h5555, 1'b1);
    #1;
    check("R8", "exc_taken", 32'(exc_taken), 32'd1);
    check("R8", "retire_valid during exc", 32'(retire_valid), 32'd0);
    fe_is(4, 16'h5555, "R4");
    alloc_req = 1'b1;
    alloc_dst = 3'd5;
    cmp_valid = 1'b1;
    cmp_idx   = 4'd5;
    cmp_data  = 16'h9999;
    #1;
    check("R10", "alloc_ok during exc", 32'(alloc_ok), 32'd0);
    @(negedge clk);
    alloc_req = 1'b0;
    cmp_valid = 1'b0;
    q_idx.delete();
    q_dst.delete();
    #1;
    check("R8", "exc one cycle", 32'(exc_taken), 32'd0);
    arch_is(4, 16'h4444, "R8");
    fe_is(4, 16'h4444, "R9");
    fe_is(1, 16'h1111, "R9");
    check("R9", "alloc_ok after exc", 32'(alloc_ok), 32'd1);
    check("R9", "alloc_idx restart", 32'(alloc_idx), 32'd0);
    repeat (3) @(negedge clk);
    fe_is(4, 16'h4444, "R10");
    check("R9", "no retire after flush", 32'(n_ret), 32'd4);

    // Resume after recovery
    alloc(6, 0, "R9");
    complete(0, 16'h6666, 1'b0);
    repeat (2) @(negedge clk);
    arch_is(6, 16'h6666, "R7");
    check("R6", "retire count final", 32'(n_ret), 32'd5);
    check("R6", "scoreboard drained", 32'(q_idx.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule